// File: doc/BRIEF.md
# Watchdog Timer with Two-Stage Prescaler

This block is a watchdog peripheral on a simple synchronous register bus. It has three word registers: control, reload value and live count. The input clock first passes through an 8-bit linear prescaler, which divides by its setting plus one. It then passes through a power-of-two stage that divides by 16, 32, 64 or 128. Each tick from this chain decrements a 16-bit down counter.

When a tick finds the counter already at zero, the counter expires and reloads from the reload register. On expiry the block can emit a one-cycle interrupt pulse, hold a system-reset output for a fixed number of cycles, or do both. Each action has its own enable bit.

Software keeps the system alive by writing the count register, which loads the counter at once. Software can stop the count by clearing the enable bit. It can suppress the reset by clearing the reset-enable bit. In both cases the other control fields keep their values.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register reads 0, the reload register reads 0x8000, the count register reads 0x8000, and both `irq` and `sys_reset` are low.
- R2: The registers sit at byte offsets 0x0 (control), 0x4 (reload) and 0x8 (count). Control keeps only these fields: bit 0 reset-enable, bit 2 interrupt-enable, bits 4:3 divider select, bit 5 run, and bits 15:8 prescaler P. All other control bits read as 0. Reload and count read back their 16-bit values, zero-extended.
- R3: A read at any other offset returns 0. A write at any other offset changes no register.
- R4: While running, a tick occurs every (P+1)·D clocks. D is 16, 32, 64 or 128 for divider codes 0, 1, 2 and 3.
- R5: Each tick decrements a nonzero count by one. A tick that finds the count at zero is an expiry. It loads the counter from the reload register. Starting from count N, the expiry therefore falls on tick N+1.
- R6: On expiry with interrupt-enable set, `irq` is high for exactly one cycle, starting in the cycle after the expiry edge. It stays low when interrupt-enable is clear.
- R7: On expiry with reset-enable set, `sys_reset` is high for exactly 128 consecutive cycles. It stays low when reset-enable is clear.
- R8: With both actions disabled, an expiry still reloads the counter, but `irq` and `sys_reset` stay low.
- R9: A write to the count register loads the counter on that edge. It takes priority over a tick on the same edge, and a tick on that edge cannot cause an expiry.
- R10: While run is clear the count holds its value and both divider stages are held at zero. The first tick after run is set therefore arrives a full (P+1)·D clocks later.
- R11: A write to the reload register does not change a running count. The new value is used from the next expiry onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| irq | output | 1 | One-cycle interrupt pulse on expiry |
| sys_reset | output | 1 | System-reset request, held for the configured number of cycles |

## Verification
The bench measures the exact cycle distance from the enabling write to the interrupt for several prescaler and divider settings, each started from a different count. A divider chain that is not cleared while stopped, or that is off by one in either stage, gives the wrong distance. The bench measures the width of the reset pulse and checks that a one-cycle interrupt does not stretch. It refreshes the counter repeatedly to confirm that no expiry slips through. It also changes the reload value in mid-count: a design that copies the new reload value straight into the counter shows a wrong count or a wrong expiry time. Finally, it writes to unmapped offsets and to reserved control bits. A design with sloppy decoding would corrupt a register or read back nonzero bits.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W = 16,
  parameter int PS_W = 8,
  parameter int RST_CYCLES = 128,
  parameter logic [15:0] RELOAD_INIT = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              sys_reset
);
  localparam logic [ADDR_W-1:0] OFF_CTRL   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_RELOAD = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_COUNT  = ADDR_W'(8);
  localparam int DIV_W = 7;
  localparam int RST_W = $clog2(RST_CYCLES + 1);

  logic             c_rst_en, c_irq_en, c_run;
  logic [1:0]       c_div;
  logic [PS_W-1:0]  c_presc;
  logic [CNT_W-1:0] reload_q, cnt_q;
  logic [PS_W-1:0]  ps_cnt;
  logic [DIV_W-1:0] dv_cnt, div_last;
  logic [RST_W-1:0] rst_cnt;

  wire wr_ctrl   = reg_we && reg_addr == OFF_CTRL;
  wire wr_reload = reg_we && reg_addr == OFF_RELOAD;
  wire wr_cnt    = reg_we && reg_addr == OFF_COUNT;

  assign div_last = DIV_W'((8'd16 << c_div) - 8'd1);
  wire ps_hit = ps_cnt == c_presc;
  wire dv_hit = dv_cnt == div_last;
  wire tick   = c_run && ps_hit && dv_hit;
  wire expire = tick && cnt_q == '0 && !wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_rst_en <= 1'b0;
      c_irq_en <= 1'b0;
      c_run    <= 1'b0;
      c_div    <= '0;
      c_presc  <= '0;
      reload_q <= CNT_W'(RELOAD_INIT);
    end else begin
      if (wr_ctrl) begin
        c_rst_en <= reg_wdata[0];
        c_irq_en <= reg_wdata[2];
        c_div    <= reg_wdata[4:3];
        c_run    <= reg_wdata[5];
        c_presc  <= reg_wdata[8 +: PS_W];
      end
      if (wr_reload) reload_q <= reg_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_cnt <= '0;
      dv_cnt <= '0;
    end else if (!c_run) begin
      ps_cnt <= '0;
      dv_cnt <= '0;
    end else if (ps_hit) begin
      ps_cnt <= '0;
      dv_cnt <= dv_hit ? '0 : dv_cnt + 1'b1;
    end else begin
      ps_cnt <= ps_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_W'(RELOAD_INIT);
    else if (wr_cnt) cnt_q <= reg_wdata[CNT_W-1:0];
    else if (tick)   cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      rst_cnt <= '0;
    end else begin
      irq <= expire && c_irq_en;
      if (expire && c_rst_en) rst_cnt <= RST_W'(RST_CYCLES);
      else if (rst_cnt != '0) rst_cnt <= rst_cnt - 1'b1;
    end
  end

  assign sys_reset = rst_cnt != '0;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_CTRL: begin
        reg_rdata[0]           = c_rst_en;
        reg_rdata[2]           = c_irq_en;
        reg_rdata[4:3]         = c_div;
        reg_rdata[5]           = c_run;
        reg_rdata[8 +: PS_W]   = c_presc;
      end
      OFF_RELOAD: reg_rdata[CNT_W-1:0] = reload_q;
      OFF_COUNT:  reg_rdata[CNT_W-1:0] = cnt_q;
      default:    reg_rdata = '0;
    endcase
  end

  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(c_irq_en));
  a_r7_reset_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_reset) |-> $past(c_rst_en));
  a_r9_refresh_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(reg_wdata[CNT_W-1:0]));
  a_r10_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_run && !wr_cnt) |=> $stable(cnt_q));
endmodule

// File: tb/wdog_timer_tb_top.sv
module wdog_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, sys_reset;
  int unsigned cyc = 0;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_timer dut_i (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sys_reset(sys_reset));

  localparam int NV = 6;
  localparam int V_P [NV] = '{0, 0, 1, 2, 0, 3};
  localparam int V_D [NV] = '{0, 1, 0, 3, 2, 1};
  localparam int V_N [NV] = '{2, 1, 1, 0, 3, 2};
  localparam int V_E [NV] = '{48, 64, 64, 384, 256, 384};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_irq(input int unsigned t0, output int unsigned dt);
    dt = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq) begin dt = cyc - t0; return; end
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int unsigned t0, dt;
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(4'h0, v); chk("R1 ctrl", v, 0);
    rd(4'h4, v); chk("R1 reload", v, 32'h8000);
    rd(4'h8, v); chk("R1 count", v, 32'h8000);
    chk("R1 irq", irq, 0);
    chk("R1 sys_reset", sys_reset, 0);
    rd(4'hC, v); chk("R3 unmapped read", v, 0);

    wr(4'h0, 32'hFFFF_FFDF); rd(4'h0, v); chk("R2 ctrl mask", v, 32'h0000_FF1D);
    wr(4'h4, 32'hFFFF_1234); rd(4'h4, v); chk("R2 reload", v, 32'h1234);
    wr(4'h8, 32'hABCD_0042); rd(4'h8, v); chk("R9 count write", v, 32'h0042);
    wr(4'hC, 32'hFFFF_FFFF); wr(4'h1, 32'h0000_0000);
    rd(4'h0, v); chk("R3 ctrl untouched", v, 32'h0000_FF1D);
    rd(4'h4, v); chk("R3 reload untouched", v, 32'h1234);
    rd(4'h8, v); chk("R3 count untouched", v, 32'h0042);
    rd(4'hC, v); chk("R3 unmapped still zero", v, 0);
    wr(4'h0, 0); wr(4'h4, 32'h8000);

    // R4 R5 R6 R10: vector table
    for (int k = 0; k < NV; k++) begin
      wr(4'h0, 0);
      wr(4'h8, V_N[k]);
      wr(4'h0, (V_P[k] << 8) | (V_D[k] << 3) | 32'h24);
      t0 = cyc;
      wait_irq(t0, dt);
      chk("R4 tick period / R10 first tick", dt, V_E[k]);
      rd(4'h8, v); chk("R5 reload on expiry", v, 32'h8000);
      chk("R7 no reset when disabled", sys_reset, 0);
      @(negedge clk); chk("R6 irq one cycle", irq, 0);
    end

    // R7
    wr(4'h0, 0); wr(4'h8, 0); wr(4'h0, 32'h21);
    t0 = cyc; dt = 0; hi = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (irq) chk("R7 no irq when disabled", irq, 0);
      if (sys_reset) begin
        if (hi == 0) dt = cyc - t0;
        hi++;
      end
    end
    chk("R7 reset start", dt, 16);
    chk("R7 reset width", hi, 128);

    // R8
    wr(4'h0, 0); wr(4'h8, 0); wr(4'h0, 32'h20);
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq || sys_reset) hi++;
    end
    chk("R8 no actions", hi, 0);
    rd(4'h8, v); chk("R8 reload still happens", v, 32'h8000);

    // R10 stop holds
    wr(4'h0, 0); wr(4'h8, 32'h100); wr(4'h0, 32'h20);
    repeat (40) @(negedge clk);
    wr(4'h0, 0);
    rd(4'h8, v); chk("R10 count at stop", v, 32'h00FE);
    repeat (200) @(negedge clk);
    rd(4'h8, v2); chk("R10 count held", v2, v);

    // R9 refresh prevents expiry
    wr(4'h0, 0); wr(4'h8, 3); wr(4'h0, 32'h25);
    hi = 0;
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 38; i++) begin
        @(negedge clk);
        if (irq || sys_reset) hi++;
      end
      wr(4'h8, 3);
    end
    chk("R9 refresh keeps alive", hi, 0);

    // R11
    wr(4'h0, 0); wr(4'h8, 5); wr(4'h0, 32'h24);
    t0 = cyc;
    wr(4'h4, 7);
    rd(4'h8, v); chk("R11 count undisturbed", v, 5);
    wait_irq(t0, dt);
    chk("R11 expiry time unchanged", dt, 96);
    rd(4'h8, v); chk("R11 new reload used", v, 7);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule